// File: doc/BRIEF.md
# Slot-Partitioned Counting Register Scoreboard

This block records which destination registers of each warp still have writes in flight. Every warp owns two independent slot tables, one per issue slot. An issue port reserves the destination registers of an instruction in the table of the slot it issued from. A writeback port retires them from that same table. A combinational hazard port answers whether a candidate instruction touches any register still pending in a chosen slot of a chosen warp.

A table entry is not a single busy bit. It is a register tag with a small counter of outstanding writes. Two back-to-back writes to one register from one slot therefore stay tracked until both have retired. The tables are small fixed-size associative arrays. The reservation port is atomic: when the counter of a matched register is already at its ceiling, or there are not enough free entries for the new registers, `rsv_stall_o` rises in the same cycle and no part of that reservation is recorded.

Top module: `sb_slot_scoreboard`

## Requirements
- R1: After reset every slot table of every warp is empty: `hazard_o` is 0 for any candidate and `rsv_stall_o` is 0.
- R2: An accepted reservation of a nonzero register for warp w and slot s (slot index is one bit, 0 or 1) makes that register pending only in table (w, s). The same register checked in the other slot or in another warp gives no hazard.
- R3: Register number 0 means "no operand". It is never reserved and never produces a hazard.
- R4: Each accepted reservation of a register that is already pending in that table raises its outstanding count by one. After two reservations and one release, the register is still pending.
- R5: A release of a pending register lowers its count by one. The entry is removed, and it no longer causes a hazard, only when the count reaches zero.
- R6: A release of a register that has no entry in the addressed table is ignored and changes no state.
- R7: A reservation and a release of the same pending register in the same warp and slot in one cycle leave its count unchanged.
- R8: The hazard check is combinational on the current table state. It is true when any source operand, any destination operand or the predicate operand of the candidate equals a pending register of the selected table.
- R9: A reservation that matches a register whose count already equals the ceiling (3 at default parameters) raises `rsv_stall_o` in that cycle. None of its destinations are recorded.
- R10: A reservation needing more new entries than the table has free (4 entries at default) raises `rsv_stall_o` and records nothing. A reservation that only matches existing entries of a full table is accepted.
- R11: A register named twice among the destinations of one reservation is counted once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rsv_valid_i | input | 1 | Reservation request |
| rsv_warp_i | input | WARP_W | Warp of the reservation |
| rsv_slot_i | input | 1 | Issue slot of the reservation |
| rsv_dst_i | input | N_DST*REG_W | Destination registers to reserve, 0 = none |
| rsv_stall_o | output | 1 | Reservation refused (count ceiling or table full) |
| rel_valid_i | input | 1 | Release request |
| rel_warp_i | input | WARP_W | Warp of the release |
| rel_slot_i | input | 1 | Issue slot of the release |
| rel_dst_i | input | N_DST*REG_W | Destination registers to release, 0 = none |
| chk_warp_i | input | WARP_W | Warp of the candidate |
| chk_slot_i | input | 1 | Slot table to check |
| chk_src_i | input | N_SRC*REG_W | Candidate source registers |
| chk_dst_i | input | N_DST*REG_W | Candidate destination registers |
| chk_pred_i | input | REG_W | Candidate predicate register |
| hazard_o | output | 1 | Candidate touches a pending register |

## Verification
The hardest states to reach are the two refusal conditions: a counter sitting exactly at its ceiling, and a table whose entries are all taken. Neither can be seen directly at the ports. The stimulus fills one register of one slot with three writes, then offers a mixed reservation (a new register plus the saturated one). It proves that nothing was recorded by checking that the new register never shows a hazard, and that exactly three releases clear the old one. A second table is filled with four distinct registers. It is then offered a new register, which must stall, and a pair of already-pending registers, which must be accepted. Releases of those registers then confirm the incremented counts.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int unsigned SB_SLOTS = 2;
  typedef logic sb_slot_t;
endpackage

// File: rtl/sb_reg_match.sv
module sb_reg_match #(
  parameter int unsigned REG_W = 6,
  parameter int unsigned N     = 2
) (
  input  logic [REG_W-1:0]        key_i,
  input  logic [N-1:0][REG_W-1:0] list_i,
  output logic                    hit_o
);
  logic [N-1:0] eq;

  for (genvar k = 0; k < N; k++) begin : g_cmp
    assign eq[k] = (list_i[k] == key_i) && (|list_i[k]);
  end

  assign hit_o = |eq;
endmodule

// File: rtl/sb_slot_table.sv
module sb_slot_table #(
  parameter int unsigned REG_W   = 6,
  parameter int unsigned N_DST   = 2,
  parameter int unsigned N_CHK   = 6,
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned CNT_W   = 2,
  localparam int unsigned USED_W = $clog2(ENTRIES + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        rsv_req_i,
  input  logic [N_DST-1:0][REG_W-1:0] rsv_regs_i,
  input  logic                        rel_req_i,
  input  logic [N_DST-1:0][REG_W-1:0] rel_regs_i,
  input  logic [N_CHK-1:0][REG_W-1:0] chk_regs_i,
  output logic                        stall_o,
  output logic                        hit_o,
  output logic [USED_W-1:0]           used_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [ENTRIES-1:0][REG_W-1:0] tag_q;
  logic [ENTRIES-1:0][CNT_W-1:0] cnt_q;
  logic [ENTRIES-1:0]            vld;
  logic [ENTRIES-1:0]            rsv_m, rel_m, chk_m;
  logic [ENTRIES-1:0]            rsv_hit, rel_hit, chk_hit, sat;
  logic [ENTRIES-1:0]            taken;
  logic [ENTRIES-1:0][REG_W-1:0] alloc_tag;
  logic [N_DST-1:0]              need_new;
  logic                          overflow, full, apply;
  logic [USED_W-1:0]             n_new, n_free;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    assign vld[e] = |cnt_q[e];

    sb_reg_match #(.REG_W(REG_W), .N(N_DST)) u_rsv_m (
      .key_i(tag_q[e]), .list_i(rsv_regs_i), .hit_o(rsv_m[e]));
    sb_reg_match #(.REG_W(REG_W), .N(N_DST)) u_rel_m (
      .key_i(tag_q[e]), .list_i(rel_regs_i), .hit_o(rel_m[e]));
    sb_reg_match #(.REG_W(REG_W), .N(N_CHK)) u_chk_m (
      .key_i(tag_q[e]), .list_i(chk_regs_i), .hit_o(chk_m[e]));

    assign rsv_hit[e] = vld[e] & rsv_m[e];
    assign rel_hit[e] = vld[e] & rel_m[e];
    assign chk_hit[e] = vld[e] & chk_m[e];
    assign sat[e]     = rsv_hit[e] & (cnt_q[e] == CNT_MAX);
  end

  // Destinations that need a fresh entry: nonzero, not pending, first occurrence.
  always_comb begin
    for (int k = 0; k < N_DST; k++) begin
      logic seen;
      seen = 1'b0;
      for (int e = 0; e < ENTRIES; e++)
        if (vld[e] && tag_q[e] == rsv_regs_i[k]) seen = 1'b1;
      for (int j = 0; j < k; j++)
        if (rsv_regs_i[j] == rsv_regs_i[k]) seen = 1'b1;
      need_new[k] = (|rsv_regs_i[k]) && !seen;
    end
  end

  always_comb begin
    n_new  = '0;
    n_free = '0;
    for (int k = 0; k < N_DST; k++) n_new = n_new + USED_W'(need_new[k]);
    for (int e = 0; e < ENTRIES; e++) n_free = n_free + USED_W'(!vld[e]);
  end

  // Lowest free entry goes to the lowest new destination.
  always_comb begin
    taken     = '0;
    alloc_tag = '0;
    for (int k = 0; k < N_DST; k++) begin
      logic found;
      found = 1'b0;
      for (int e = 0; e < ENTRIES; e++) begin
        if (need_new[k] && !found && !vld[e] && !taken[e]) begin
          taken[e]     = 1'b1;
          alloc_tag[e] = rsv_regs_i[k];
          found        = 1'b1;
        end
      end
    end
  end

  assign overflow = |sat;
  assign full     = n_new > n_free;
  assign stall_o  = rsv_req_i & (overflow | full);
  assign apply    = rsv_req_i & ~(overflow | full);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q <= '0;
      cnt_q <= '0;
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (apply && taken[e]) begin
          tag_q[e] <= alloc_tag[e];
          cnt_q[e] <= CNT_W'(1);
        end else begin
          cnt_q[e] <= cnt_q[e]
                    + CNT_W'(apply & rsv_hit[e])
                    - CNT_W'(rel_req_i & rel_hit[e]);
        end
      end
    end
  end

  assign hit_o = |chk_hit;

  always_comb begin
    used_o = '0;
    for (int e = 0; e < ENTRIES; e++) used_o = used_o + USED_W'(vld[e]);
  end
endmodule

// File: rtl/sb_slot_scoreboard.sv
module sb_slot_scoreboard
  import sb_pkg::*;
#(
  parameter int unsigned NUM_WARPS = 4,
  parameter int unsigned REG_W     = 6,
  parameter int unsigned N_DST     = 2,
  parameter int unsigned N_SRC     = 3,
  parameter int unsigned ENTRIES   = 4,
  parameter int unsigned CNT_W     = 2,
  localparam int unsigned WARP_W   = $clog2(NUM_WARPS),
  localparam int unsigned N_CHK    = N_SRC + N_DST + 1,
  localparam int unsigned N_TBL    = NUM_WARPS * SB_SLOTS,
  localparam int unsigned USED_W   = $clog2(ENTRIES + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        rsv_valid_i,
  input  logic [WARP_W-1:0]           rsv_warp_i,
  input  logic                        rsv_slot_i,
  input  logic [N_DST-1:0][REG_W-1:0] rsv_dst_i,
  output logic                        rsv_stall_o,
  input  logic                        rel_valid_i,
  input  logic [WARP_W-1:0]           rel_warp_i,
  input  logic                        rel_slot_i,
  input  logic [N_DST-1:0][REG_W-1:0] rel_dst_i,
  input  logic [WARP_W-1:0]           chk_warp_i,
  input  logic                        chk_slot_i,
  input  logic [N_SRC-1:0][REG_W-1:0] chk_src_i,
  input  logic [N_DST-1:0][REG_W-1:0] chk_dst_i,
  input  logic [REG_W-1:0]            chk_pred_i,
  output logic                        hazard_o
);
  logic [N_CHK-1:0][REG_W-1:0] chk_regs;
  logic [N_TBL-1:0]            tbl_stall, tbl_hit;
  logic [N_TBL-1:0][USED_W-1:0] tbl_used;
  logic [WARP_W:0]             rsv_idx, rel_idx, chk_idx;

  assign chk_regs = {chk_pred_i, chk_dst_i, chk_src_i};
  assign rsv_idx  = {rsv_warp_i, rsv_slot_i};
  assign rel_idx  = {rel_warp_i, rel_slot_i};
  assign chk_idx  = {chk_warp_i, chk_slot_i};

  for (genvar t = 0; t < N_TBL; t++) begin : g_tbl
    sb_slot_table #(
      .REG_W(REG_W), .N_DST(N_DST), .N_CHK(N_CHK),
      .ENTRIES(ENTRIES), .CNT_W(CNT_W)
    ) u_tbl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .rsv_req_i  (rsv_valid_i && rsv_idx == (WARP_W+1)'(t)),
      .rsv_regs_i (rsv_dst_i),
      .rel_req_i  (rel_valid_i && rel_idx == (WARP_W+1)'(t)),
      .rel_regs_i (rel_dst_i),
      .chk_regs_i (chk_regs),
      .stall_o    (tbl_stall[t]),
      .hit_o      (tbl_hit[t]),
      .used_o     (tbl_used[t])
    );
  end

  assign rsv_stall_o = tbl_stall[rsv_idx];
  assign hazard_o    = tbl_hit[chk_idx];
endmodule

// File: rtl/sb_slot_scoreboard_sva.sv
module sb_slot_scoreboard_sva #(
  parameter int unsigned NUM_WARPS = 4,
  parameter int unsigned ENTRIES   = 4,
  localparam int unsigned WARP_W   = $clog2(NUM_WARPS),
  localparam int unsigned N_TBL    = NUM_WARPS * 2,
  localparam int unsigned USED_W   = $clog2(ENTRIES + 1)
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          rsv_valid_i,
  input logic                          rsv_stall_o,
  input logic                          rel_valid_i,
  input logic                          hazard_o,
  input logic [WARP_W:0]               rsv_idx,
  input logic [WARP_W:0]               rel_idx,
  input logic [WARP_W:0]               chk_idx,
  input logic [N_TBL-1:0][USED_W-1:0]  tbl_used
);
  logic [USED_W-1:0] used_rsv, used_rel, used_chk;
  assign used_rsv = tbl_used[rsv_idx];
  assign used_rel = tbl_used[rel_idx];
  assign used_chk = tbl_used[chk_idx];

  // R9 / R10: a refusal only answers a request
  a_r9_stall_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsv_stall_o |-> rsv_valid_i);

  // R9 / R10: a refused reservation records nothing
  a_r10_stall_no_alloc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsv_valid_i && rsv_stall_o && !rel_valid_i)
      |=> tbl_used[$past(rsv_idx)] == $past(used_rsv));

  // R2: an accepted reservation never frees entries
  a_r2_accept_no_shrink: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsv_valid_i && !rsv_stall_o && !rel_valid_i)
      |=> tbl_used[$past(rsv_idx)] >= $past(used_rsv));

  // R5 / R6: a lone release never adds entries
  a_r5_release_no_grow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_valid_i && !rsv_valid_i)
      |=> tbl_used[$past(rel_idx)] <= $past(used_rel));

  // R2: a table not addressed by either port keeps its occupancy
  a_r2_idle_table_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(rsv_valid_i && rsv_idx == '0) && !(rel_valid_i && rel_idx == '0))
      |=> $stable(tbl_used[0]));

  // R1 / R8: an empty table raises no hazard
  a_r1_empty_no_hazard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (used_chk == '0) |-> !hazard_o);
endmodule

bind sb_slot_scoreboard sb_slot_scoreboard_sva #(
  .NUM_WARPS(NUM_WARPS), .ENTRIES(ENTRIES)
) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rsv_valid_i (rsv_valid_i),
  .rsv_stall_o (rsv_stall_o),
  .rel_valid_i (rel_valid_i),
  .hazard_o    (hazard_o),
  .rsv_idx     (rsv_idx),
  .rel_idx     (rel_idx),
  .chk_idx     (chk_idx),
  .tbl_used    (tbl_used)
);

// File: tb/sb_slot_scoreboard_bench.sv
`timescale 1ns/1ps
module sb_slot_scoreboard_bench;
  localparam int NW = 4, RW = 6, ND = 2, NS = 3;

  typedef struct packed {
    logic rv; logic [1:0] rw; logic rs; logic [5:0] rd0, rd1;
    logic lv; logic [1:0] lw; logic ls; logic [5:0] ld0, ld1;
    logic [1:0] cw; logic cs; logic [5:0] c0, c2, cd, cp;
    logic xs, xh; logic [3:0] rq;
  } vec_t;

  function automatic vec_t mk(int rv, int rw, int rs, int rd0, int rd1,
                              int lv, int lw, int ls, int ld0, int ld1,
                              int cw, int cs, int c0, int c2, int cd, int cp,
                              int xs, int xh, int rq);
    vec_t v;
    v.rv = 1'(rv); v.rw = 2'(rw); v.rs = 1'(rs); v.rd0 = 6'(rd0); v.rd1 = 6'(rd1);
    v.lv = 1'(lv); v.lw = 2'(lw); v.ls = 1'(ls); v.ld0 = 6'(ld0); v.ld1 = 6'(ld1);
    v.cw = 2'(cw); v.cs = 1'(cs); v.c0 = 6'(c0); v.c2 = 6'(c2);
    v.cd = 6'(cd); v.cp = 6'(cp); v.xs = 1'(xs); v.xh = 1'(xh); v.rq = 4'(rq);
    return v;
  endfunction

  localparam int NV = 45;
  // rsv(v,w,s,d0,d1) rel(v,w,s,d0,d1) chk(w,s,src0,src2,dst,pred) exp(stall,hazard) req
  localparam vec_t VECS [NV] = '{
    mk(0,0,0, 0, 0, 0,0,0, 0, 0, 0,0, 5, 0, 0, 0, 0,0, 1), // R1
    mk(1,0,0, 5, 0, 0,0,0, 0, 0, 0,0, 5, 0, 0, 0, 0,0, 2), // R2
    mk(0,0,0, 0, 0, 0,0,0, 0, 0, 0,0, 5, 0, 0, 0, 0,1, 2),
    mk(0,0,0, 0, 0, 0,0,0, 0, 0, 0,1, 5, 0, 0, 0, 0,0, 2),
    mk(0,0,0, 0, 0, 0,0,0, 0, 0, 1,0, 5, 0, 0, 0, 0,0, 2),
    mk(1,0,0, 5, 0, 0,0,0, 0, 0, 0,0, 5, 0, 0, 0, 0,1, 4), // R4
    mk(0,0,0, 0, 0, 1,0,0, 5, 0, 0,0, 5, 0, 0, 0, 0,1, 4),
    mk(0,0,0, 0, 0, 0,0,0, 0, 0, 0,0, 5, 0, 0, 0, 0,1, 4),
    mk(0,0,0, 0, 0, 1,0,0, 5, 0, 0,0, 5, 0, 0, 0, 0,1, 5), // R5
    mk(0,0,0, 0, 0, 0,0,0, 0, 0, 0,0, 5, 0, 0, 0, 0,0, 5),
    mk(0,0,0, 0, 0, 1,0,0, 9, 0, 0,0, 9, 0, 0, 0, 0,0, 6), // R6
    mk(1,2,1, 7, 0, 0,0,0, 0, 0, 0,0, 9, 0, 0, 0, 0,0, 6),
    mk(1,2,1, 7, 0, 1,2,1, 7, 0, 2,1, 7, 0, 0, 0, 0,1, 7), // R7
    mk(0,0,0, 0, 0, 0,0,0, 0, 0, 2,1, 7, 0, 0, 0, 0,1, 7),
    mk(0,0,0, 0, 0, 1,2,1, 7, 0, 2,1, 7, 0, 0, 0, 0,1, 7),
    mk(0,0,0, 0, 0, 0,0,0, 0, 0, 2,1, 7, 0, 0, 0, 0,0, 7),
    mk(1,1,1,12,13, 0,0,0, 0, 0, 1,1, 0, 0,12, 0, 0,0, 8), // R8
    mk(0,0,0, 0, 0, 0,0,0, 0, 0, 1,1, 0, 0,12, 0, 0,1, 8),
    mk(0,0,0, 0, 0, 0,0,0, 0, 0, 1,1, 0, 0, 0,13, 0,1, 8),
    mk(0,0,0, 0, 0, 0,0,0, 0, 0, 1,1, 0,13, 0, 0, 0,1, 8),
    mk(0,0,0, 0, 0, 0,0,0, 0, 0, 1,1,14, 0, 0, 0, 0,0, 8),
    mk(1,3,0, 0, 0, 0,0,0, 0, 0, 3,0, 0, 0, 0, 0, 0,0, 3), // R3
    mk(0,0,0, 0, 0, 0,0,0, 0, 0, 3,0, 0, 0, 0, 0, 0,0, 3),
    mk(1,3,0,20,20, 0,0,0, 0, 0, 3,0,20, 0, 0, 0, 0,0,11), // R11
    mk(0,0,0, 0, 0, 1,3,0,20, 0, 3,0,20, 0, 0, 0, 0,1,11),
    mk(0,0,0, 0, 0, 0,0,0, 0, 0, 3,0,20, 0, 0, 0, 0,0,11),
    mk(1,0,1,30, 0, 0,0,0, 0, 0, 0,1,30, 0, 0, 0, 0,0, 9), // R9
    mk(1,0,1,30, 0, 0,0,0, 0, 0, 0,1,30, 0, 0, 0, 0,1, 9),
    mk(1,0,1,30, 0, 0,0,0, 0, 0, 0,1,30, 0, 0, 0, 0,1, 9),
    mk(1,0,1,31,30, 0,0,0, 0, 0, 0,1,30, 0, 0, 0, 1,1, 9),
    mk(0,0,0, 0, 0, 0,0,0, 0, 0, 0,1,31, 0, 0, 0, 0,0, 9),
    mk(0,0,0, 0, 0, 1,0,1,30, 0, 0,1,30, 0, 0, 0, 0,1, 9),
    mk(0,0,0, 0, 0, 1,0,1,30, 0, 0,1,30, 0, 0, 0, 0,1, 9),
    mk(0,0,0, 0, 0, 1,0,1,30, 0, 0,1,30, 0, 0, 0, 0,1, 9),
    mk(0,0,0, 0, 0, 0,0,0, 0, 0, 0,1,30, 0, 0, 0, 0,0, 9),
    mk(1,2,0,40,41, 0,0,0, 0, 0, 2,0,40, 0, 0, 0, 0,0,10), // R10
    mk(1,2,0,42,43, 0,0,0, 0, 0, 2,0,40, 0, 0, 0, 0,1,10),
    mk(1,2,0,44, 0, 0,0,0, 0, 0, 2,0,43, 0, 0, 0, 1,1,10),
    mk(0,0,0, 0, 0, 0,0,0, 0, 0, 2,0,44, 0, 0, 0, 0,0,10),
    mk(1,2,0,40,41, 0,0,0, 0, 0, 2,0,44, 0, 0, 0, 0,0,10),
    mk(0,0,0, 0, 0, 1,2,0,40,41, 2,0,40, 0, 0, 0, 0,1,10),
    mk(0,0,0, 0, 0, 1,2,0,40,41, 2,0,40, 0, 0, 0, 0,1,10),
    mk(0,0,0, 0, 0, 1,2,0,42,43, 2,0,40, 0, 0, 0, 0,0, 5),
    mk(1,2,0,44,45, 0,0,0, 0, 0, 2,0,44, 0, 0, 0, 0,0,10),
    mk(0,0,0, 0, 0, 0,0,0, 0, 0, 2,0,45, 0, 0, 0, 0,1,10)
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic rsv_valid, rsv_slot, rel_valid, rel_slot, chk_slot;
  logic [1:0] rsv_warp, rel_warp, chk_warp;
  logic [ND-1:0][RW-1:0] rsv_dst, rel_dst, chk_dst;
  logic [NS-1:0][RW-1:0] chk_src;
  logic [RW-1:0] chk_pred;
  logic rsv_stall, hazard;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sb_slot_scoreboard #(.NUM_WARPS(NW), .REG_W(RW), .N_DST(ND), .N_SRC(NS))
  u_sb_slot_scoreboard (
    .clk_i(clk), .rst_ni(rst_n),
    .rsv_valid_i(rsv_valid), .rsv_warp_i(rsv_warp), .rsv_slot_i(rsv_slot),
    .rsv_dst_i(rsv_dst), .rsv_stall_o(rsv_stall),
    .rel_valid_i(rel_valid), .rel_warp_i(rel_warp), .rel_slot_i(rel_slot),
    .rel_dst_i(rel_dst),
    .chk_warp_i(chk_warp), .chk_slot_i(chk_slot), .chk_src_i(chk_src),
    .chk_dst_i(chk_dst), .chk_pred_i(chk_pred), .hazard_o(hazard)
  );

  task automatic check(string what, int rq, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL R%0d %s: actual %b expected %b", rq, what, act, exp);
    end
  endtask

  task automatic drive(vec_t v);
    rsv_valid = v.rv; rsv_warp = v.rw; rsv_slot = v.rs;
    rsv_dst[0] = v.rd0; rsv_dst[1] = v.rd1;
    rel_valid = v.lv; rel_warp = v.lw; rel_slot = v.ls;
    rel_dst[0] = v.ld0; rel_dst[1] = v.ld1;
    chk_warp = v.cw; chk_slot = v.cs;
    chk_src[0] = v.c0; chk_src[1] = '0; chk_src[2] = v.c2;
    chk_dst[0] = v.cd; chk_dst[1] = '0; chk_pred = v.cp;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  initial begin
    drive('0);
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    #1 check("stall in reset", 1, rsv_stall, 1'b0);
    check("hazard in reset", 1, hazard, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      #1;
      check($sformatf("vec %0d stall", i), int'(VECS[i].rq), rsv_stall, VECS[i].xs);
      check($sformatf("vec %0d hazard", i), int'(VECS[i].rq), hazard, VECS[i].xh);
    end

    // R1: asynchronous reset clears pending state (44, 45 are pending in w2 s0)
    @(negedge clk);
    drive('0);
    chk_warp = 2'd2; chk_slot = 1'b0; chk_src[0] = 6'd45;
    #1 check("w2s0 45 pending before reset", 5, hazard, 1'b1);
    rst_n = 1'b0;
    #1 check("reset clears hazard", 1, hazard, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int t = 0; t < 2*NW; t++) begin
      @(negedge clk);
      chk_warp = 2'(t >> 1); chk_slot = 1'(t); chk_src[0] = 6'd44; chk_pred = 6'd45;
      #1 check($sformatf("table %0d empty after reset", t), 1, hazard, 1'b0);
    end

    // R9: saturated count refuses even a lone repeat; R10 path stays clear
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      drive('0);
      rsv_valid = 1'b1; rsv_warp = 2'd1; rsv_slot = 1'b0; rsv_dst[0] = 6'd50;
      #1 check($sformatf("repeat %0d of reg 50", k), 9, rsv_stall, k == 3);
    end
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R1 watchdog: actual hung expected done");
      finish_run();
    end
  end
endmodule